// File: doc/BRIEF.md
# Two-Input Join Firing Shell

This block wraps a computation node that takes one token from a left input and one from a right input and produces one result token. Each input has a one-slot holding register. An input token is accepted whenever its slot is empty, or when the node fires in the same cycle and so frees the slot. A token that arrives before its partner waits in its slot. The node fires as soon as both slots hold a token and the downstream stage reports free space. The data path adds the two held values and sends the sum downstream as a one-cycle output pulse. The sum is one bit wider than the inputs.

Every cycle the shell reports whether the node was active or idle. For an idle cycle it also reports why. The reason can be that the left token was missing, that the right token was missing, or that both were missing or the output had no room. Recording these tags over a live run gives back the activity word of the node, and shows on which side each stall came from. The firing decision depends only on which tokens are present. It never depends on their values.

Top module: `join_fire_shell`

## Requirements
- R1: The node fires in a cycle only when both slots are full and outReady is high in that cycle. When these hold, it always fires. `active` is high in the cycle after a firing, and low in every other cycle.
- R2: Each firing produces exactly one `outValid` pulse in the following cycle. With it, `outData` equals the zero-extended sum of the two held tokens. No pulse appears without a firing.
- R3: Whether the node fires does not depend on the data values. Zero operands and all-ones operands fire exactly as other values do.
- R4: `stallCode` is registered with the same timing as `active`. It reads 2'b00 for a firing cycle, 2'b01 when only the left slot was empty, and 2'b10 when only the right slot was empty. It reads 2'b11 when both slots were empty, or when both were full but outReady was low.
- R5: A full slot that does not fire in the current cycle drives its ready output low. An offered token is then not accepted. The held token and its data are kept until the node fires.
- R6: A ready output is high when its slot is empty, and also when the node fires in that cycle. So with both inputs streaming and outReady high, the node fires on every cycle.
- R7: A synchronous active-high reset empties both slots. It drives `active` and `outValid` low and sets `stallCode` to 2'b11, so both ready outputs are high once reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| leftValid | input | 1 | Left token offered |
| leftData | input | DATA_W | Left token value |
| leftReady | output | 1 | Left token accepted this cycle if offered |
| rightValid | input | 1 | Right token offered |
| rightData | input | DATA_W | Right token value |
| rightReady | output | 1 | Right token accepted this cycle if offered |
| outReady | input | 1 | Downstream has space for a token this cycle |
| outValid | output | 1 | One-cycle result token pulse |
| outData | output | DATA_W+1 | Sum of the two consumed tokens |
| active | output | 1 | Node fired in the previous cycle |
| stallCode | output | 2 | Activity or idle reason for the previous cycle |

## Verification
An offered token enters its slot at a clock edge. The node can fire in the next cycle at the earliest. The resulting `active`, `stallCode`, `outValid` and `outData` values become visible after the edge that ends that firing cycle. The ready outputs are combinational and are valid within the cycle in which the token is offered. The bench drives inputs on the falling edge and checks the ready outputs one time step later. At the next falling edge it checks the registered status against the decision that its own token model predicted for the cycle before. Each predicted sum is queued when the firing is decided, and the monitor pops it on the falling edge where `outValid` is expected.

// File: rtl/fshell_pkg.sv
package fshell_pkg;

  typedef enum logic [1:0] {
    CODE_FIRE       = 2'b00,
    CODE_LEFT_MISS  = 2'b01,
    CODE_RIGHT_MISS = 2'b10,
    CODE_WAIT_BOTH  = 2'b11
  } stallCode_e;

  localparam int SIDES = 2;

  typedef struct packed {
    logic             fire;
    logic [SIDES-1:0] take;
  } strobes_t;

endpackage

// File: rtl/fshell_ctrl.sv
module fshell_ctrl
  import fshell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SIDES-1:0] inValid,
  input  logic             outReady,
  output logic [SIDES-1:0] inReady,
  output logic [SIDES-1:0] slotFull,
  output strobes_t         strb,
  output logic             active,
  output logic [1:0]       stallCode
);

  logic       fireNow;
  stallCode_e nextCode;

  assign fireNow = (&slotFull) && outReady;

  always_comb begin
    if (fireNow)                      nextCode = CODE_FIRE;
    else if (slotFull == 2'b00)       nextCode = CODE_WAIT_BOTH;
    else if (!slotFull[0])            nextCode = CODE_LEFT_MISS;
    else if (!slotFull[1])            nextCode = CODE_RIGHT_MISS;
    else                              nextCode = CODE_WAIT_BOTH;
  end

  for (genvar side = 0; side < SIDES; side++) begin : g_side
    assign inReady[side]  = !slotFull[side] || fireNow;
    assign strb.take[side] = inValid[side] && inReady[side];

    always_ff @(posedge clk) begin
      if (rst)                  slotFull[side] <= 1'b0;
      else if (strb.take[side]) slotFull[side] <= 1'b1;
      else if (fireNow)         slotFull[side] <= 1'b0;
    end

    a_r5_no_token_lost: assert property (@(posedge clk) disable iff (rst)
      (inValid[side] && !inReady[side]) |=> slotFull[side]);
  end

  assign strb.fire = fireNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      stallCode <= CODE_WAIT_BOTH;
    end else begin
      active    <= fireNow;
      stallCode <= nextCode;
    end
  end

  a_r1_fire_needs_space: assert property (@(posedge clk) disable iff (rst)
    active |-> $past(outReady));

  a_r4_code_tracks_activity: assert property (@(posedge clk) disable iff (rst)
    active == (stallCode == CODE_FIRE));

endmodule

// File: rtl/fshell_dpath.sv
module fshell_dpath
  import fshell_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int OUT_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] leftData,
  input  logic [DATA_W-1:0] rightData,
  input  strobes_t          strb,
  input  logic [SIDES-1:0]  slotFull,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData
);

  logic [DATA_W-1:0] slotData [SIDES];
  logic [DATA_W-1:0] inData   [SIDES];

  assign inData[0] = leftData;
  assign inData[1] = rightData;

  for (genvar side = 0; side < SIDES; side++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                  slotData[side] <= '0;
      else if (strb.take[side]) slotData[side] <= inData[side];
    end

    a_r5_held_data_stable: assert property (@(posedge clk) disable iff (rst)
      (slotFull[side] && !strb.fire) |=> $stable(slotData[side]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.fire;
      if (strb.fire)
        outData <= {1'b0, slotData[0]} + {1'b0, slotData[1]};
    end
  end

endmodule

// File: rtl/join_fire_shell.sv
module join_fire_shell
  import fshell_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int OUT_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              leftValid,
  input  logic [DATA_W-1:0] leftData,
  output logic              leftReady,
  input  logic              rightValid,
  input  logic [DATA_W-1:0] rightData,
  output logic              rightReady,
  input  logic              outReady,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData,
  output logic              active,
  output logic [1:0]        stallCode
);

  strobes_t         strb;
  logic [SIDES-1:0] slotFull;
  logic [SIDES-1:0] inReady;

  fshell_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   ({rightValid, leftValid}),
    .outReady  (outReady),
    .inReady   (inReady),
    .slotFull  (slotFull),
    .strb      (strb),
    .active    (active),
    .stallCode (stallCode)
  );

  fshell_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .leftData  (leftData),
    .rightData (rightData),
    .strb      (strb),
    .slotFull  (slotFull),
    .outValid  (outValid),
    .outData   (outData)
  );

  assign leftReady  = inReady[0];
  assign rightReady = inReady[1];

  a_r2_pulse_per_fire: assert property (@(posedge clk) disable iff (rst)
    outValid == active);

endmodule

// File: tb/sim_join_fire_shell.sv
`timescale 1ns/1ps
module sim_join_fire_shell;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          leftValid = 1'b0, rightValid = 1'b0, outReady = 1'b0;
  logic [DW-1:0] leftData = '0, rightData = '0;
  logic          leftReady, rightReady, outValid, active;
  logic [DW:0]   outData;
  logic [1:0]    stallCode;

  always #2 clk = ~clk;

  join_fire_shell #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .leftValid(leftValid), .leftData(leftData), .leftReady(leftReady),
    .rightValid(rightValid), .rightData(rightData), .rightReady(rightReady),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .active(active), .stallCode(stallCode)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;
  string actTag = "R1";

  logic [DW:0] expQ [$];

  bit          mL = 0, mR = 0;
  logic [DW-1:0] dL = '0, dR = '0;
  bit          expAct = 0;
  logic [1:0]  expCode = 2'b11;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops the scoreboard on each result pulse (R2)
  always @(negedge clk) begin
    if (!rst && !done && outValid === 1'b1) begin
      if (expQ.size() == 0) begin
        chk(0, "R2 unexpected outValid", 1, 0);
      end else begin
        logic [DW:0] e;
        e = expQ.pop_front();
        chk(outData === e, "R2 sum", int'(outData), int'(e));
      end
    end
  end

  // driver: one cycle of stimulus against the bench's own token model
  task automatic step(input bit lv, input logic [DW-1:0] ld,
                      input bit rv, input logic [DW-1:0] rd, input bit ordy);
    bit fire, erl, err;
    @(negedge clk);
    chk(active === expAct, actTag, int'(active), int'(expAct));
    chk(stallCode === expCode, "R4 stallCode", int'(stallCode), int'(expCode));
    leftValid = lv; leftData = ld; rightValid = rv; rightData = rd; outReady = ordy;
    #1;
    fire = mL && mR && ordy;
    erl  = !mL || fire;
    err  = !mR || fire;
    chk(leftReady === erl, (mL && !fire) ? "R5 leftReady" : "R6 leftReady",
        int'(leftReady), int'(erl));
    chk(rightReady === err, (mR && !fire) ? "R5 rightReady" : "R6 rightReady",
        int'(rightReady), int'(err));
    if (fire) expQ.push_back({1'b0, dL} + {1'b0, dR});
    expAct = fire;
    if (fire)            expCode = 2'b00;
    else if (!mL && !mR) expCode = 2'b11;
    else if (!mL)        expCode = 2'b01;
    else if (!mR)        expCode = 2'b10;
    else                 expCode = 2'b11;
    if (lv && erl) begin mL = 1; dL = ld; end else if (fire) mL = 0;
    if (rv && err) begin mR = 1; dR = rd; end else if (fire) mR = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, '0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(active === 1'b0, "R7 active", int'(active), 0);
    chk(outValid === 1'b0, "R7 outValid", int'(outValid), 0);
    chk(stallCode === 2'b11, "R7 stallCode", int'(stallCode), 3);
    chk(leftReady === 1'b1 && rightReady === 1'b1, "R7 ready",
        int'({leftReady, rightReady}), 3);
    rst = 1'b0;

    // simultaneous arrival
    step(1, 8'd5, 1, 8'd7, 1);
    idle(2);

    // left early, second left offer refused while waiting (R5)
    step(1, 8'd20, 0, '0, 1);
    step(1, 8'd99, 0, '0, 1);
    step(0, '0, 0, '0, 1);
    step(0, '0, 1, 8'd3, 1);
    idle(2);

    // right early
    step(0, '0, 1, 8'd40, 1);
    idle(1);
    step(1, 8'd2, 0, '0, 1);
    idle(2);

    // output blocked
    step(1, 8'd1, 1, 8'd1, 0);
    step(1, 8'd9, 1, 8'd9, 0);
    step(0, '0, 0, '0, 0);
    step(0, '0, 0, '0, 1);
    idle(2);

    // back-to-back stream (R6)
    for (int i = 0; i < 8; i++) step(1, 8'(i * 10), 1, 8'(i * 3), 1);
    idle(3);

    // stream with intermittent backpressure
    for (int i = 0; i < 8; i++) step(1, 8'(100 + i), (i % 3) != 1, 8'(i), (i % 2) == 0);
    idle(4);

    // R3: extreme data values fire like any others
    actTag = "R3 active";
    step(1, 8'd0, 1, 8'd0, 1);
    step(1, 8'hFF, 1, 8'hFF, 1);
    step(1, 8'h80, 1, 8'h7F, 1);
    idle(3);
    actTag = "R1";

    chk(expQ.size() == 0, "R2 missing outputs", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule